// File: doc/BRIEF.md
# Key-serviced watchdog timer

This block is a watchdog that runs from a free-running oscillator clock and must be kept alive by software. An 8-bit up-counter advances on every clock in which the tick enable is high. Software keeps it from expiring by writing an ordered pair of keys to the key register: first 0x55, then 0xAA. The counter value is always visible on `cnt_o`, so software can decide whether there is still time to service it. Software treats a count of 254 or more as too late.

A watchdog event is raised by any of three faults. The counter can expire. Software can write a key value other than the two legal ones. Or software can write the control register with the wrong check-bit pattern. The action taken on an event depends on a mode bit in the control register. With the mode bit set, the event drives `irq_n` low for a fixed 512 cycles. With it clear, the event drives `wdrst_n` low for a short fixed pulse. That pulse also returns the counter, the key tracker and the mode bit to their defaults. The mode defaults to reset. Any event that arrives while `irq_n` is still low is discarded.

Software writes both registers through one write port. `wr_sel` picks the target, and `wr_data` carries the value for one clock with `wr_en` high.

Top module: `kwdt_top`

## Requirements
- R1: The counter increments by one at each clock edge where `tick_en` is 1, and it holds its value when `tick_en` is 0. Its value is readable on `cnt_o`.
- R2: A key write (`wr_sel`=0) of 0x55 arms the tracker. A following key write of 0xAA clears the counter to 0 on that edge. Repeated 0x55 writes and tick cycles between the two writes keep the tracker armed.
- R3: A key write of 0xAA when the tracker is not armed leaves the counter unchanged and raises no event.
- R4: A key write of any value other than 0x55 or 0xAA raises an event and disarms the tracker.
- R5: A control write (`wr_sel`=1) with `wr_data[5:3]` equal to 3'b101 loads the mode bit from `wr_data[0]` and raises no event. Any other pattern in bits [5:3] raises an event and leaves the mode unchanged.
- R6: A tick while the counter holds 255 raises a timeout event and wraps the counter to 0.
- R7: With mode 1, an event drives `irq_n` low from the following edge for exactly 512 cycles. `wdrst_n` stays high throughout.
- R8: Events of any kind that occur while `irq_n` is low are dropped. They neither lengthen the pulse nor assert `wdrst_n`. The first event after `irq_n` returns high is taken again.
- R9: With mode 0, an event drives `wdrst_n` low from the following edge for 8 cycles. During that pulse the counter is held at 0 and writes and ticks are ignored. Afterwards the counter is 0, the tracker is disarmed and the mode is 0.
- R10: Asserting `rst_n` low immediately forces `cnt_o`=0, `irq_n`=1 and `wdrst_n`=1, and sets the mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 key register, 1 control register |
| wr_data | input | 8 | Write value |
| cnt_o | output | 8 | Current counter value |
| irq_n | output | 1 | Watchdog interrupt, active low, fixed pulse |
| wdrst_n | output | 1 | Watchdog reset, active low, fixed pulse |

## Verification
Several properties are checked on every cycle:
- the counter steps, holds and wraps correctly;
- a bad key or a bad check write disarms the tracker or leaves the mode untouched;
- each event starts the right pulse for the current mode;
- an event dropped during the interrupt pulse never produces a reset;
- the two outputs are never low together;
- the interrupt low run is exactly 512 cycles.

Only the bench scenarios can show the end-to-end behaviour. These include:
- service sequences, including a repeated 0x55 and ticks between the keys;
- a 0xAA key ignored when the tracker is not armed;
- a timeout in each mode;
- writes ignored inside the reset pulse;
- timeouts and bad keys swallowed inside one interrupt pulse, with the counter value checked afterwards.

// File: rtl/kwdt_pkg.sv
`timescale 1ns/1ps
package kwdt_pkg;
   // target of a register write
   typedef enum logic {
      WSEL_KEY  = 1'b0,
      WSEL_CTRL = 1'b1
   } wsel_e;

   // sources that can raise a watchdog event
   typedef struct packed {
      logic timeout;
      logic bad_key;
      logic bad_chk;
   } ev_src_t;
endpackage

// File: rtl/kwdt_counter.sv
`timescale 1ns/1ps
module kwdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             timeout
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // a service clear in the same cycle as the last tick wins over the timeout
   assign timeout = tick & ~hold & ~clr & (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (hold | clr) cnt <= '0;
      else if (tick)       cnt <= cnt + 1'b1;
   end

   p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !hold && !clr && cnt != CNT_MAX |=> cnt == CNT_W'($past(cnt) + 1'b1));
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !hold && !clr |=> $stable(cnt));
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> cnt == '0);
   p_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> cnt == '0);
endmodule

// File: rtl/kwdt_keytrack.sv
`timescale 1ns/1ps
module kwdt_keytrack
   import kwdt_pkg::*;
#(
   parameter int              DATA_W   = 8,
   parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
   parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA,
   parameter int              CHK_W    = 3,
   parameter int              CHK_LSB  = 3,
   parameter logic [CHK_W-1:0] CHK_OK  = 3'b101,
   parameter int              MODE_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              wr_en,
   input  wsel_e             wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              clr,
   output logic              bad_key,
   output logic              bad_chk,
   output logic              mode
);
   logic armed;
   logic key_wr, ctrl_wr, is_arm, is_fire, chk_ok;

   assign key_wr  = wr_en & ~hold & (wr_sel == WSEL_KEY);
   assign ctrl_wr = wr_en & ~hold & (wr_sel == WSEL_CTRL);
   assign is_arm  = (wr_data == KEY_ARM);
   assign is_fire = (wr_data == KEY_FIRE);
   assign chk_ok  = (wr_data[CHK_LSB +: CHK_W] == CHK_OK);

   assign clr     = key_wr & is_fire & armed;
   assign bad_key = key_wr & ~is_arm & ~is_fire;
   assign bad_chk = ctrl_wr & ~chk_ok;

   // tracker: armed only right after a 0x55; any other key disarms it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed <= 1'b0;
      else if (hold)   armed <= 1'b0;
      else if (key_wr) armed <= is_arm;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mode <= 1'b0;
      else if (hold)             mode <= 1'b0;
      else if (ctrl_wr & chk_ok) mode <= wr_data[MODE_BIT];
   end

   p_clr_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !armed);
   p_bad_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_key |=> !armed);
   p_mode_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bad_chk |=> $stable(mode));
   p_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !armed && !mode);
endmodule

// File: rtl/kwdt_action.sv
`timescale 1ns/1ps
module kwdt_action #(
   parameter int IRQ_LEN = 512,
   parameter int RST_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic mode,
   output logic irq_n,
   output logic wdrst_n,
   output logic hold
);
   localparam int IRQ_W = $clog2(IRQ_LEN + 1);
   localparam int RST_W = $clog2(RST_LEN + 1);

   logic [IRQ_W-1:0] irq_cnt;
   logic             irq_busy, rst_busy, fire;

   assign irq_busy = (irq_cnt != '0);
   // events during either pulse are not captured
   assign fire     = event_i & ~irq_busy & ~rst_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           irq_cnt <= '0;
      else if (fire & mode) irq_cnt <= IRQ_W'(IRQ_LEN);
      else if (irq_busy)    irq_cnt <= irq_cnt - 1'b1;
   end

   generate
      if (RST_LEN == 1) begin : g_rst_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_busy <= 1'b0;
            else        rst_busy <= fire & ~mode;
         end
      end else begin : g_rst_cnt
         logic [RST_W-1:0] rst_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            rst_cnt <= '0;
            else if (fire & ~mode) rst_cnt <= RST_W'(RST_LEN);
            else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
         end
         assign rst_busy = (rst_cnt != '0);
      end
   endgenerate

   assign irq_n   = ~irq_busy;
   assign wdrst_n = ~rst_busy;
   assign hold    = rst_busy;

   // run length of the low interrupt level, used only by p_irq_len_r7
   logic [IRQ_W:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_run <= '0;
      else if (!irq_n) low_run <= low_run + 1'b1;
      else             low_run <= '0;
   end

   p_irq_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      event_i && irq_n && wdrst_n && mode |=> !irq_n);
   p_irq_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> low_run == (IRQ_W+1)'(IRQ_LEN));
   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      event_i && !irq_n |=> wdrst_n);
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n || wdrst_n);
   p_rst_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      event_i && irq_n && wdrst_n && !mode |=> !wdrst_n);
endmodule

// File: rtl/kwdt_top.sv
`timescale 1ns/1ps
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter int               CNT_W    = 8,
   parameter logic [DATA_W-1:0] KEY_ARM  = 8'h55,
   parameter logic [DATA_W-1:0] KEY_FIRE = 8'hAA,
   parameter int               CHK_W    = 3,
   parameter int               CHK_LSB  = 3,
   parameter logic [CHK_W-1:0]  CHK_OK   = 3'b101,
   parameter int               MODE_BIT = 0,
   parameter int               IRQ_LEN  = 512,
   parameter int               RST_LEN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              irq_n,
   output logic              wdrst_n
);
   // elaboration-time parameter checks
   if (CNT_W < 2)                    begin : g_bad_cnt  $error("CNT_W must be at least 2");      end
   if (IRQ_LEN < 1)                  begin : g_bad_irq  $error("IRQ_LEN must be positive");      end
   if (RST_LEN < 1)                  begin : g_bad_rst  $error("RST_LEN must be positive");      end
   if (CHK_LSB + CHK_W > DATA_W)     begin : g_bad_chk  $error("check field exceeds data");      end
   if (MODE_BIT >= DATA_W)           begin : g_bad_mode $error("mode bit outside data");         end
   if (MODE_BIT >= CHK_LSB && MODE_BIT < CHK_LSB + CHK_W)
                                     begin : g_ovl_mode $error("mode bit overlaps check field"); end
   if (KEY_ARM == KEY_FIRE)          begin : g_bad_key  $error("keys must differ");              end

   ev_src_t src;
   logic    hold, clr, mode, ev;

   kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .tick    (tick_en),
      .clr     (clr),
      .cnt     (cnt_o),
      .timeout (src.timeout)
   );

   kwdt_keytrack #(
      .DATA_W   (DATA_W),
      .KEY_ARM  (KEY_ARM),
      .KEY_FIRE (KEY_FIRE),
      .CHK_W    (CHK_W),
      .CHK_LSB  (CHK_LSB),
      .CHK_OK   (CHK_OK),
      .MODE_BIT (MODE_BIT)
   ) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .wr_en   (wr_en),
      .wr_sel  (wsel_e'(wr_sel)),
      .wr_data (wr_data),
      .clr     (clr),
      .bad_key (src.bad_key),
      .bad_chk (src.bad_chk),
      .mode    (mode)
   );

   assign ev = |src;

   kwdt_action #(.IRQ_LEN(IRQ_LEN), .RST_LEN(RST_LEN)) u_act (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (ev),
      .mode    (mode),
      .irq_n   (irq_n),
      .wdrst_n (wdrst_n),
      .hold    (hold)
   );

   p_reset_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> cnt_o == '0 && irq_n && wdrst_n);
endmodule

// File: tb/kwdt_top_tb.sv
`timescale 1ns/1ps
module kwdt_top_tb;
   localparam int IRQ_LEN = 512;
   localparam int RST_LEN = 8;
   localparam logic KEY = 1'b0, CTRL = 1'b1;

   logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] cnt_o;
   logic       irq_n, wdrst_n;
   int         nvec = 0, nerr = 0;

   always #4 clk = ~clk;

   kwdt_top u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .cnt_o(cnt_o),
      .irq_n(irq_n), .wdrst_n(wdrst_n)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic service();
      wr(KEY, 8'h55); wr(KEY, 8'hAA);
   endtask

   task automatic irq_run(output int n);
      n = 0;
      while (!irq_n) begin n++; @(negedge clk); end
   endtask

   task automatic rst_run(output int n);
      n = 0;
      while (!wdrst_n) begin n++; @(negedge clk); end
   endtask

   task automatic t_reset();
      chk("R10", "cnt after reset", cnt_o, 0);
      chk("R10", "irq_n after reset", irq_n, 1);
      chk("R10", "wdrst_n after reset", wdrst_n, 1);
   endtask

   task automatic t_count();
      ticks(37);
      chk("R1", "count after 37 ticks", cnt_o, 37);
      repeat (5) @(negedge clk);
      chk("R1", "count held without tick", cnt_o, 37);
   endtask

   task automatic t_service();
      service();
      chk("R2", "cleared by 55,AA", cnt_o, 0);
      ticks(20);
      wr(KEY, 8'h55); wr(KEY, 8'h55); wr(KEY, 8'hAA);
      chk("R2", "cleared by 55,55,AA", cnt_o, 0);
      ticks(9); wr(KEY, 8'h55); ticks(3);
      chk("R2", "armed count before AA", cnt_o, 12);
      wr(KEY, 8'hAA);
      chk("R2", "cleared with ticks between keys", cnt_o, 0);
      chk("R2", "no event from service", {30'd0, irq_n, wdrst_n}, 3);
   endtask

   task automatic t_lone_aa();
      ticks(15);
      wr(KEY, 8'hAA);
      chk("R3", "lone AA keeps count", cnt_o, 15);
      chk("R3", "lone AA no reset", wdrst_n, 1);
      service(); ticks(4); wr(KEY, 8'hAA);
      chk("R3", "second AA keeps count", cnt_o, 4);
      chk("R3", "second AA no event", {30'd0, irq_n, wdrst_n}, 3);
   endtask

   task automatic t_bad_key();
      int n;
      wr(CTRL, 8'h29);
      chk("R5", "valid ctrl no event", {30'd0, irq_n, wdrst_n}, 3);
      service(); ticks(6);
      wr(KEY, 8'h55); wr(KEY, 8'h12);
      chk("R4", "bad key raises irq", irq_n, 0);
      chk("R7", "no reset in irq mode", wdrst_n, 1);
      irq_run(n);
      chk("R7", "irq low length", n, IRQ_LEN);
      wr(KEY, 8'hAA);
      chk("R4", "bad key disarmed tracker", cnt_o, 6);
   endtask

   task automatic t_bad_chk();
      int n;
      wr(CTRL, 8'h00);
      chk("R5", "bad check raises irq (mode kept 1)", irq_n, 0);
      chk("R5", "bad check no reset", wdrst_n, 1);
      irq_run(n);
      wr(CTRL, 8'h28);
      chk("R5", "valid ctrl mode0 no event", {30'd0, irq_n, wdrst_n}, 3);
      wr(CTRL, 8'h39);
      chk("R5", "bad check in mode0 raises reset", wdrst_n, 0);
      rst_run(n);
      chk("R9", "reset pulse length", n, RST_LEN);
   endtask

   task automatic t_timeout_irq();
      int n;
      wr(CTRL, 8'h29); service();
      ticks(255);
      chk("R6", "count 255 no event", {23'd0, cnt_o, irq_n}, {23'd0, 8'd255, 1'b1});
      ticks(1);
      chk("R6", "wrap to 0", cnt_o, 0);
      chk("R7", "timeout irq low", irq_n, 0);
      irq_run(n);
      chk("R7", "timeout irq length", n, IRQ_LEN);
   endtask

   task automatic t_drop();
      int  n;
      bit  rst_seen;
      service(); ticks(200);
      wr(KEY, 8'h00);
      n = 1; rst_seen = 0;
      tick_en = 1'b1;
      for (int i = 1; i < 2000; i++) begin
         if (i == 100) wr(KEY, 8'h00); else @(negedge clk);
         if (!wdrst_n) rst_seen = 1;
         if (irq_n) break;
         n++;
      end
      tick_en = 1'b0;
      chk("R8", "pulse not lengthened", n, IRQ_LEN);
      chk("R8", "no reset from dropped events", rst_seen, 0);
      chk("R8", "count after 512 ticks", cnt_o, 200);
      wr(KEY, 8'h00);
      chk("R8", "event after pulse taken", irq_n, 0);
      irq_run(n);
   endtask

   task automatic t_timeout_rst();
      int n;
      wr(CTRL, 8'h28); service();
      ticks(256);
      chk("R6", "timeout in reset mode", wdrst_n, 0);
      chk("R9", "count 0 in reset", cnt_o, 0);
      chk("R9", "no irq in reset mode", irq_n, 1);
      n = 1; tick_en = 1'b1;
      for (int i = 1; i < 100; i++) begin
         if (i == 1) wr(CTRL, 8'h29);
         else if (i == 2) wr(KEY, 8'h55);
         else @(negedge clk);
         if (wdrst_n) break;
         n++;
      end
      tick_en = 1'b0;
      chk("R9", "reset pulse length", n, RST_LEN);
      chk("R9", "counter held during reset", cnt_o, 0);
      ticks(3); wr(KEY, 8'hAA);
      chk("R9", "tracker disarmed by reset", cnt_o, 3);
      wr(KEY, 8'h00);
      chk("R9", "mode 0 after reset", wdrst_n, 0);
      rst_run(n);
   endtask

   task automatic t_async();
      wr(CTRL, 8'h29); ticks(9); wr(KEY, 8'h00);
      repeat (10) @(negedge clk);
      rst_n = 1'b0; #1;
      chk("R10", "async irq_n", irq_n, 1);
      chk("R10", "async cnt", cnt_o, 0);
      chk("R10", "async wdrst_n", wdrst_n, 1);
      @(negedge clk); rst_n = 1'b1; @(negedge clk);
      wr(KEY, 8'h00);
      chk("R10", "mode 0 after reset", wdrst_n, 0);
      while (!wdrst_n) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_service();
      t_lone_aa();
      t_bad_key();
      t_bad_chk();
      t_timeout_irq();
      t_drop();
      t_timeout_rst();
      t_async();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule